// File: doc/BRIEF.md
# LIN Master Frame Transmitter

This block drives the master side of a LIN bus frame on a single-wire transmit pin. Before a frame, software writes up to eight response bytes into a small message buffer and places the frame settings on the configuration inputs: a 6-bit identifier, a length code, a publish/subscribe direction and a checksum kind. It then pulses `hdr_req`. The block latches the settings and produces the break, the delimiter, the sync byte and the protected identifier. When the master owns the response, it follows these at once with the data bytes and a checksum byte, with no software action in between.

Every transmitted bit is compared with the `rx` pin at mid-bit. A mismatch stops the frame and raises an error flag. Three sticky flags report the outcome: header sent, response sent and bit error. All three are cleared when the next request is accepted. Bit timing comes from `samp_tick`, which pulses `OVS` times per bit time.

The controller state machine has states IDLE, BREAK, DELIM, SYNC, PID, DATA and CKSUM. The transitions are as follows:
- IDLE to BREAK when a request is accepted.
- BREAK to DELIM, DELIM to SYNC and SYNC to PID, each when its field ends.
- PID to DATA for a publish frame.
- PID to IDLE for a subscribe frame.
- DATA to DATA while bytes remain.
- DATA to CKSUM after the last byte.
- CKSUM to IDLE at the end of the stop bit.
- Any active state to IDLE on a read-back mismatch.

Top module: `lin_master_tx`

## Requirements
- R1: `hdr_req` is accepted only while `busy` is low. The configuration inputs are latched in that cycle. In the next cycle `busy` is high, `tx` is 0 and all three flags are clear.
- R2: A frame opens with `BRK_BITS` dominant bit times (13 by default) and then one recessive delimiter bit. Each bit lasts `OVS` pulses of `samp_tick`.
- R3: The sync byte 0x55 follows the delimiter. After it comes the protected identifier {P1,P0,ID[5:0]}, with P0 = ID0^ID1^ID2^ID4 and P1 = ~(ID1^ID3^ID4^ID5).
- R4: Every byte is sent as a 0 start bit, then eight data bits least significant first, then a 1 stop bit.
- R5: In a publish frame (`cfg_pub`=1) with length code L, buffer bytes 0 to L are sent in index order (L+1 bytes) directly after the identifier. The checksum byte follows the last of them.
- R6: The checksum is the bitwise inverse of the 8-bit sum with end-around carry. With `cfg_enh`=0 the sum covers the data bytes only. With `cfg_enh`=1 the protected identifier is added as well.
- R7: After the checksum stop bit of an error-free publish frame, `flag_done` and `flag_hdr` are 1 and `busy` is 0.
- R8: In a subscribe frame (`cfg_pub`=0) the block returns to idle after the identifier stop bit. `flag_hdr` is then 1 and `flag_done` is 0.
- R9: If `rx` differs from `tx` at mid-bit, the frame is aborted. `tx` returns to 1, `flag_err` is set, `busy` falls and `flag_done` stays 0.
- R10: `hdr_req` while `busy` is high is ignored. The running frame is unchanged, and no new frame starts once it ends.
- R11: Buffer writes while `busy` is high are dropped. The buffer contents are then those written before the frame.
- R12: `tx` is 1 whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_tick | input | 1 | Oversampling tick, OVS per bit time |
| cfg_id | input | 6 | Frame identifier |
| cfg_len | input | 3 | Data length code, bytes = code + 1 |
| cfg_pub | input | 1 | 1: master publishes response, 0: subscribe |
| cfg_enh | input | 1 | 1: enhanced checksum, 0: classic |
| buf_we | input | 1 | Message buffer write enable |
| buf_idx | input | 3 | Message buffer byte index |
| buf_byte | input | 8 | Message buffer write data |
| hdr_req | input | 1 | Header request strobe |
| rx | input | 1 | Bus read-back |
| tx | output | 1 | Bus transmit, 1 is recessive |
| busy | output | 1 | Frame in progress |
| flag_done | output | 1 | Response sent without error |
| flag_hdr | output | 1 | Header sent |
| flag_err | output | 1 | Read-back bit error |

## Verification
The response-complete event and the read-back check can land in the same bit, namely the stop bit of the checksum. The bench provokes this by inverting `rx` only across that stop bit. It then expects the error to win: `flag_err` set, `flag_done` clear and `flag_hdr` still set. A second overlap is a header request or a buffer write arriving while a frame runs. The bench judges it by decoding the whole frame from `tx` against arithmetic expectations, then checking that the bus stays idle afterwards and that the following frame carries the original buffer bytes.

// File: rtl/lin_mtx_pkg.sv
package lin_mtx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BREAK,
        ST_DELIM,
        ST_SYNC,
        ST_PID,
        ST_DATA,
        ST_CKSUM
    } mst_e;

    localparam logic [7:0] SYNC_BYTE = 8'h55;

endpackage

// File: rtl/lin_pid_gen.sv
module lin_pid_gen (
    input  logic [5:0] id,
    output logic [7:0] pid
);
    logic p0, p1;

    always_comb begin
        p0  = id[0] ^ id[1] ^ id[2] ^ id[4];
        p1  = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
        pid = {p1, p0, id};
    end
endmodule

// File: rtl/lin_cks_acc.sv
module lin_cks_acc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] init,
    input  logic         add,
    input  logic [W-1:0] din,
    output logic [W-1:0] cks
);
    logic [W-1:0] acc;
    logic [W:0]   wide;

    always_comb begin
        wide = {1'b0, acc} + {1'b0, din};
        cks  = ~acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc <= '0;
        else if (clr)
            acc <= init;
        else if (add)
            acc <= wide[W-1:0] + {{(W-1){1'b0}}, wide[W]};
    end
endmodule

// File: rtl/lin_bit_timer.sv
module lin_bit_timer #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic samp_tick,
    output logic mid,
    output logic last
);
    localparam int CNTW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam int MIDP = OVS / 2;

    logic [CNTW-1:0] cnt;

    always_comb begin
        mid  = samp_tick && (cnt == CNTW'(MIDP));
        last = samp_tick && (cnt == CNTW'(OVS - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart)
            cnt <= '0;
        else if (samp_tick)
            cnt <= (cnt == CNTW'(OVS - 1)) ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/lin_master_tx.sv
module lin_master_tx
    import lin_mtx_pkg::*;
#(
    parameter int OVS      = 16,
    parameter int BRK_BITS = 13,
    parameter int NBYTES   = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      samp_tick,
    input  logic [5:0]                cfg_id,
    input  logic [$clog2(NBYTES)-1:0] cfg_len,
    input  logic                      cfg_pub,
    input  logic                      cfg_enh,
    input  logic                      buf_we,
    input  logic [$clog2(NBYTES)-1:0] buf_idx,
    input  logic [7:0]                buf_byte,
    input  logic                      hdr_req,
    input  logic                      rx,
    output logic                      tx,
    output logic                      busy,
    output logic                      flag_done,
    output logic                      flag_hdr,
    output logic                      flag_err
);
    localparam int IW  = $clog2(NBYTES);
    localparam int BLW = $clog2((BRK_BITS > 10) ? BRK_BITS : 10);

    mst_e            state, state_nx;
    logic            tx_q;
    logic [8:0]      sh;
    logic [BLW-1:0]  bits_left;
    logic [IW-1:0]   idx;
    logic [5:0]      id_q;
    logic [IW-1:0]   len_q;
    logic            pub_q, enh_q;
    logic [7:0]      dbuf [NBYTES];

    logic            bt_mid, bt_last;
    logic            start, active, mism, fend, step;
    logic [7:0]      pid, cks;
    logic            cks_clr, cks_add;
    logic [7:0]      add_byte;
    logic [IW-1:0]   idx_nx;

    lin_pid_gen u_pid (.id(id_q), .pid(pid));

    lin_bit_timer #(.OVS(OVS)) u_tmr (
        .clk(clk), .rst_n(rst_n), .restart(start), .samp_tick(samp_tick),
        .mid(bt_mid), .last(bt_last)
    );

    lin_cks_acc #(.W(8)) u_cks (
        .clk(clk), .rst_n(rst_n), .clr(cks_clr),
        .init(enh_q ? pid : 8'h00), .add(cks_add), .din(add_byte), .cks(cks)
    );

    always_comb begin
        active  = (state != ST_IDLE);
        start   = hdr_req && !active;
        mism    = active && bt_mid && (rx != tx_q);
        fend    = active && bt_last && (bits_left == '0);
        step    = active && bt_last && (bits_left != '0);
        idx_nx  = idx + 1'b1;
        cks_clr = fend && (state == ST_SYNC);
        cks_add = fend && ((state == ST_PID && pub_q) ||
                           (state == ST_DATA && idx != len_q));
        add_byte = (state == ST_PID) ? dbuf[0] : dbuf[idx_nx];
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_BREAK;
            ST_BREAK: if (mism) state_nx = ST_IDLE; else if (fend) state_nx = ST_DELIM;
            ST_DELIM: if (mism) state_nx = ST_IDLE; else if (fend) state_nx = ST_SYNC;
            ST_SYNC:  if (mism) state_nx = ST_IDLE; else if (fend) state_nx = ST_PID;
            ST_PID:   if (mism) state_nx = ST_IDLE;
                      else if (fend) state_nx = pub_q ? ST_DATA : ST_IDLE;
            ST_DATA:  if (mism) state_nx = ST_IDLE;
                      else if (fend && idx == len_q) state_nx = ST_CKSUM;
            ST_CKSUM: if (mism || fend) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // message buffer: writable only between frames
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NBYTES; i++) dbuf[i] <= 8'h00;
        end else if (buf_we && !active) begin
            dbuf[buf_idx] <= buf_byte;
        end
    end

    // serializer and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q      <= 1'b1;
            sh        <= '0;
            bits_left <= '0;
            idx       <= '0;
            id_q      <= '0;
            len_q     <= '0;
            pub_q     <= 1'b0;
            enh_q     <= 1'b0;
            flag_done <= 1'b0;
            flag_hdr  <= 1'b0;
            flag_err  <= 1'b0;
        end else if (start) begin
            tx_q      <= 1'b0;
            sh        <= '0;
            bits_left <= BLW'(BRK_BITS - 1);
            idx       <= '0;
            id_q      <= cfg_id;
            len_q     <= cfg_len;
            pub_q     <= cfg_pub;
            enh_q     <= cfg_enh;
            flag_done <= 1'b0;
            flag_hdr  <= 1'b0;
            flag_err  <= 1'b0;
        end else if (mism) begin
            tx_q     <= 1'b1;
            flag_err <= 1'b1;
        end else if (step) begin
            tx_q      <= sh[0];
            sh        <= {1'b0, sh[8:1]};
            bits_left <= bits_left - 1'b1;
        end else if (fend) begin
            unique case (state)
                ST_BREAK: begin
                    tx_q      <= 1'b1;
                    bits_left <= '0;
                end
                ST_DELIM: begin
                    tx_q <= 1'b0; sh <= {1'b1, SYNC_BYTE}; bits_left <= BLW'(9);
                end
                ST_SYNC: begin
                    tx_q <= 1'b0; sh <= {1'b1, pid}; bits_left <= BLW'(9);
                end
                ST_PID: begin
                    flag_hdr <= 1'b1;
                    if (pub_q) begin
                        tx_q <= 1'b0; sh <= {1'b1, dbuf[0]}; bits_left <= BLW'(9);
                        idx  <= '0;
                    end else begin
                        tx_q <= 1'b1;
                    end
                end
                ST_DATA: begin
                    tx_q      <= 1'b0;
                    bits_left <= BLW'(9);
                    if (idx == len_q) begin
                        sh <= {1'b1, cks};
                    end else begin
                        sh  <= {1'b1, dbuf[idx_nx]};
                        idx <= idx_nx;
                    end
                end
                ST_CKSUM: begin
                    flag_done <= 1'b1;
                    tx_q      <= 1'b1;
                end
                default: tx_q <= 1'b1;
            endcase
        end
    end

    assign tx   = tx_q;
    assign busy = active;

endmodule

// File: rtl/lin_master_tx_chk.sv
module lin_master_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic hdr_req,
    input logic tx,
    input logic busy,
    input logic flag_done,
    input logic flag_hdr,
    input logic flag_err
);
    // R1
    req_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_req && !busy) |=> busy);

    // R1
    start_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!tx && !flag_done && !flag_hdr && !flag_err));

    // R12
    idle_recessive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx);

    // R9
    err_excl_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_done && flag_err));

    // R7
    done_has_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_done |-> flag_hdr);

    // R8
    end_reports_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (flag_done || flag_hdr || flag_err));
endmodule

bind lin_master_tx lin_master_tx_chk u_lin_master_tx_chk (
    .clk(clk), .rst_n(rst_n), .hdr_req(hdr_req), .tx(tx), .busy(busy),
    .flag_done(flag_done), .flag_hdr(flag_hdr), .flag_err(flag_err)
);

// File: tb/test_lin_master_tx.sv
module test_lin_master_tx;
    localparam int CLK_PERIOD = 10;
    localparam int OVS        = 4;
    localparam int BRK        = 13;
    localparam int NB         = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] cfg_id = '0;
    logic [2:0] cfg_len = '0;
    logic       cfg_pub = 1'b0, cfg_enh = 1'b0;
    logic       buf_we = 1'b0;
    logic [2:0] buf_idx = '0;
    logic [7:0] buf_byte = '0;
    logic       hdr_req = 1'b0;
    logic       inj = 1'b0;
    logic       rx, tx, busy, flag_done, flag_hdr, flag_err;
    logic [7:0] model_buf [NB];

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;

    assign rx = tx ^ inj;

    always #(CLK_PERIOD/2) clk = ~clk;

    lin_master_tx #(.OVS(OVS), .BRK_BITS(BRK), .NBYTES(NB)) i_lin_master_tx (
        .clk(clk), .rst_n(rst_n), .samp_tick(1'b1),
        .cfg_id(cfg_id), .cfg_len(cfg_len), .cfg_pub(cfg_pub), .cfg_enh(cfg_enh),
        .buf_we(buf_we), .buf_idx(buf_idx), .buf_byte(buf_byte),
        .hdr_req(hdr_req), .rx(rx), .tx(tx), .busy(busy),
        .flag_done(flag_done), .flag_hdr(flag_hdr), .flag_err(flag_err)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pid_of(input logic [5:0] id);
        logic p0, p1;
        p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
        p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
        return {p1, p0, id};
    endfunction

    function automatic logic [7:0] cks_of(input int len, input logic enh, input logic [7:0] p);
        int s;
        s = enh ? int'(p) : 0;
        for (int i = 0; i <= len; i++) begin
            s = s + int'(model_buf[i]);
            if (s > 255) s = s - 255;
        end
        return ~s[7:0];
    endfunction

    task automatic wr_buf(input int i, input logic [7:0] b, input bit update_model);
        @(negedge clk);
        buf_we = 1'b1; buf_idx = 3'(i); buf_byte = b;
        @(negedge clk);
        buf_we = 1'b0;
        if (update_model) model_buf[i] = b;
    endtask

    task automatic rx_byte(output logic [7:0] b, output logic ok, input bit kill_stop);
        int n;
        ok = 1'b1; b = '0; n = 0;
        while (tx !== 1'b0 && n < OVS * 30) begin @(negedge clk); n++; end
        if (n >= OVS * 30) ok = 1'b0;
        repeat (OVS/2) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            repeat (OVS) @(negedge clk);
            b[k] = tx;
        end
        if (kill_stop) begin
            repeat (OVS/2) @(negedge clk);
            inj = 1'b1;
            repeat (OVS) @(negedge clk);
            inj = 1'b0;
        end else begin
            repeat (OVS) @(negedge clk);
            if (tx !== 1'b1) ok = 1'b0;
        end
    endtask

    // kill: 0 none, 1 invert rx over the checksum stop bit
    task automatic run_frame(input logic [5:0] id, input int len, input logic pub,
                             input logic enh, input int kill, input bit poke);
        int n;
        logic [7:0] b;
        logic ok;
        @(negedge clk);
        cfg_id = id; cfg_len = 3'(len); cfg_pub = pub; cfg_enh = enh;
        hdr_req = 1'b1;
        @(negedge clk);
        hdr_req = 1'b0;
        chk("R1 busy after request", busy, 1);
        n = 0;
        while (tx === 1'b0 && n < BRK * OVS * 4) begin
            n++;
            if (poke && n == 5) begin
                hdr_req = 1'b1; buf_we = 1'b1; buf_idx = 3'd0; buf_byte = ~model_buf[0];
            end else begin
                hdr_req = 1'b0; buf_we = 1'b0;
            end
            @(negedge clk);
        end
        hdr_req = 1'b0; buf_we = 1'b0;
        chk("R2 break length", n, BRK * OVS);
        n = 0;
        while (tx === 1'b1 && n < OVS * 4) begin n++; @(negedge clk); end
        chk("R2 delimiter length", n, OVS);
        rx_byte(b, ok, 1'b0);
        chk("R3 sync byte", b, 8'h55);
        chk("R4 sync framing", ok, 1);
        rx_byte(b, ok, 1'b0);
        chk("R3 protected id", b, pid_of(id));
        chk("R4 pid framing", ok, 1);
        if (pub) begin
            for (int i = 0; i <= len; i++) begin
                rx_byte(b, ok, 1'b0);
                chk("R5 data byte", b, model_buf[i]);
                chk("R4 data framing", ok, 1);
            end
            rx_byte(b, ok, (kill == 1));
            chk("R6 checksum", b, cks_of(len, enh, pid_of(id)));
        end
        repeat (OVS) @(negedge clk);
        chk("R12 tx idle after frame", tx, 1);
        if (kill == 1) begin
            chk("R9 err flag on last bit", flag_err, 1);
            chk("R9 done stays clear", flag_done, 0);
            chk("R9 busy low", busy, 0);
        end else if (pub) begin
            chk("R7 done flag", flag_done, 1);
            chk("R7 hdr flag", flag_hdr, 1);
            chk("R7 busy low", busy, 0);
        end else begin
            chk("R8 hdr flag", flag_hdr, 1);
            chk("R8 done clear", flag_done, 0);
            chk("R8 busy low", busy, 0);
        end
    endtask

    initial begin
        for (int i = 0; i < NB; i++) model_buf[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk("R12 reset tx", tx, 1);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset flags", {flag_done, flag_hdr, flag_err}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // subscribe sweep over every identifier
        for (int id = 0; id < 64; id++) run_frame(6'(id), id % 8, 1'b0, id[0], 0, 1'b0);

        // publish sweep: all lengths, both checksum kinds, three patterns
        for (int pat = 0; pat < 3; pat++) begin
            for (int i = 0; i < NB; i++)
                wr_buf(i, (pat == 0) ? 8'hFF : (pat == 1) ? 8'(8'hA5 ^ (i * 37)) : 8'(i * 3 + 1), 1'b1);
            for (int len = 0; len < NB; len++)
                for (int e = 0; e < 2; e++)
                    run_frame(6'(len * 7 + pat * 11 + e), len, 1'b1, e[0], 0, 1'b0);
        end

        // R10 and R11: request and buffer write during a frame
        run_frame(6'h2A, 3, 1'b1, 1'b1, 0, 1'b1);
        begin
            int nb;
            nb = 0;
            for (int k = 0; k < OVS * 4; k++) begin
                @(negedge clk);
                if (busy !== 1'b0 || tx !== 1'b1) nb++;
            end
            chk("R10 no frame after ignored request", nb, 0);
        end
        run_frame(6'h15, 2, 1'b1, 1'b0, 0, 1'b0); // R11 original byte 0 expected

        // R9: error on the checksum stop bit, error must win over completion
        run_frame(6'h33, 1, 1'b1, 1'b1, 1, 1'b0);
        chk("R9 hdr flag kept", flag_hdr, 1);

        // R9: error during the break
        @(negedge clk);
        cfg_id = 6'h01; cfg_pub = 1'b1; hdr_req = 1'b1;
        @(negedge clk);
        hdr_req = 1'b0; inj = 1'b1;
        repeat (OVS) @(negedge clk);
        inj = 1'b0;
        @(negedge clk);
        chk("R9 err in break", flag_err, 1);
        chk("R9 abort busy", busy, 0);
        chk("R9 abort tx", tx, 1);
        chk("R9 abort no hdr", flag_hdr, 0);

        // recovery: a following frame clears the flags and completes
        run_frame(6'h3F, 0, 1'b1, 1'b0, 0, 1'b0);
        chk("R1 err cleared by new frame", flag_err, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule